// File: doc/BRIEF.md
# Paired Byte Register File with Stack Port

This block holds the working registers of a small 8-bit processor core. Eight byte registers (accumulator, flag byte, and the six general registers B, C, D, E, H, L) and a 16-bit stack pointer live here. Neighbouring logic can read and write any single byte. It can also treat register couples as 16-bit words, the first register of a couple being the upper byte. Flag values are computed outside the block and simply stored in the flag byte.

On top of plain storage the block performs 16-bit step operations (add or subtract one) on a couple or on the stack pointer. It also runs memory transfers through a single byte-wide memory port. The accumulator can be stored to, or loaded from, the address held in HL, with HL moved up or down by one afterwards. A 16-bit couple can be pushed to or popped from the stack one byte at a time. A push or pop takes two clock cycles, and `busy` marks the second cycle.

Top module: `pairreg_file`

## Requirements
- R1: After a synchronous reset every byte register reads 0x00, the stack pointer reads 0xFFFE, and `busy`, `mem_we` and `mem_re` are low.
- R2: Byte index encoding: 0=B, 1=C, 2=D, 3=E, 4=H, 5=L, 6=F, 7=A. A byte write is visible on `rd_byte` from the cycle after the clock edge.
- R3: Word code 0=BC, 1=DE, 2=HL, 3=SP. `rd_pair` returns {first register, second register}, or the stack pointer for code 3.
- R4: A 16-bit load puts `ld16_b0` into the second (low) register and `ld16_b1` into the first (high) register. For code 3 it loads the stack pointer with {b1,b0}.
- R5: A step adds or subtracts one modulo 65536 (0xFFFF+1=0x0000, 0x0000-1=0xFFFF) on the selected word. The flag byte is left unchanged.
- R6: The low four bits of F always read zero, whichever path wrote F.
- R7: Memory op 1 (store, HL up) and op 2 (store, HL down) write A to address HL in the same cycle. HL is HL+1 or HL-1 after the edge.
- R8: Memory op 3 (load, HL up) and op 4 (load, HL down) read address HL, place the byte in A, and move HL by one in the stated direction.
- R9: Memory op 5 (push) writes the high byte at SP-1 in its first cycle. It writes the low byte at SP-2 in the second cycle, with `busy` high. SP is lowered by 2 afterwards.
- R10: Memory op 6 (pop) reads the low byte at SP and then the high byte at SP+1, raising SP by 2. For push and pop, pair code 3 selects AF (A high, F low) and codes 0 to 2 select BC, DE, HL.
- R11: When several writes hit one register in the same cycle, the winner is a memory op, then a step, then a 16-bit load, then a byte write.
- R12: While `busy` is high, byte writes, 16-bit loads, steps and new memory ops have no effect.
- R13: `mem_we` and `mem_re` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_byte_sel | input | 3 | Byte read index |
| rd_byte | output | 8 | Selected byte register |
| rd_pair_sel | input | 2 | Word read code |
| rd_pair | output | 16 | Selected couple or stack pointer |
| byte_wr_en | input | 1 | Byte write strobe |
| byte_wr_sel | input | 3 | Byte write index |
| byte_wr_data | input | 8 | Byte write value |
| ld16_en | input | 1 | 16-bit load strobe |
| ld16_sel | input | 2 | 16-bit load word code |
| ld16_b0 | input | 8 | First operand byte (goes low) |
| ld16_b1 | input | 8 | Second operand byte (goes high) |
| step_en | input | 1 | 16-bit step strobe |
| step_down | input | 1 | 1 subtracts one, 0 adds one |
| step_sel | input | 2 | Step word code |
| mop | input | 3 | Memory op code (0 none, 1 to 6 as in requirements, 7 none) |
| mop_pair | input | 2 | Couple for push and pop |
| busy | output | 1 | Second cycle of a push or pop |
| mem_addr | output | 16 | Memory address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid in the same cycle |

## Verification
The hardest state to reach is the second cycle of a push. That cycle is the only time `busy` is high, and it lasts just one clock. The bench starts a push and then, in the very next cycle, drives a byte write and a step aimed at other registers. The ports must then show those registers unchanged while the low byte goes out at SP-2. Same-cycle collisions are also forced on purpose: a byte write together with a step on the same couple, and a 16-bit load together with a byte write to one of its halves.

// File: rtl/pairreg_pkg.sv
package pairreg_pkg;

    localparam int BYTE_W    = 8;
    localparam int WORD_W    = 16;
    localparam int NUM_BYTES = 8;
    localparam int IDX_W     = $clog2(NUM_BYTES);
    localparam int CODE_W    = 2;

    localparam logic [IDX_W-1:0]  IDX_F   = 3'd6;
    localparam logic [IDX_W-1:0]  IDX_A   = 3'd7;
    localparam logic [CODE_W-1:0] CODE_HL = 2'd2;
    localparam logic [CODE_W-1:0] CODE_SP = 2'd3;  // AF for stack transfers

    typedef enum logic [2:0] {
        MOP_NONE   = 3'd0,
        MOP_ST_INC = 3'd1,
        MOP_ST_DEC = 3'd2,
        MOP_LD_INC = 3'd3,
        MOP_LD_DEC = 3'd4,
        MOP_PUSH   = 3'd5,
        MOP_POP    = 3'd6,
        MOP_RSVD   = 3'd7
    } mop_e;

    typedef enum logic [1:0] {
        SQ_IDLE    = 2'd0,
        SQ_PUSH_LO = 2'd1,
        SQ_POP_HI  = 2'd2
    } sq_state_e;

    typedef struct packed {
        logic              en;
        logic [IDX_W-1:0]  idx;
        logic [BYTE_W-1:0] data;
    } byte_wr_t;

    typedef struct packed {
        logic              en;
        logic [CODE_W-1:0] code;
        logic [WORD_W-1:0] value;
    } word_wr_t;

    // Upper register of a couple; stack transfers map code 3 to A.
    function automatic logic [IDX_W-1:0] hi_idx(input logic [CODE_W-1:0] code,
                                                input logic stack);
        if (stack && code == CODE_SP) return IDX_A;
        return {code, 1'b0};
    endfunction

    // Lower register of a couple; stack transfers map code 3 to F.
    function automatic logic [IDX_W-1:0] lo_idx(input logic [CODE_W-1:0] code,
                                                input logic stack);
        if (stack && code == CODE_SP) return IDX_F;
        return {code, 1'b1};
    endfunction

    function automatic logic [WORD_W-1:0] step16(input logic [WORD_W-1:0] v,
                                                 input logic down);
        return down ? (v - 16'd1) : (v + 16'd1);
    endfunction

endpackage

// File: rtl/pairreg_bank.sv
module pairreg_bank
    import pairreg_pkg::*;
#(
    parameter logic [WORD_W-1:0] SP_INIT     = 16'hFFFE,
    parameter int                F_ZERO_BITS = 4
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  byte_wr_t                             bw,
    input  word_wr_t                             ww,
    input  logic                                 st_en,
    input  logic                                 st_down,
    input  logic [CODE_W-1:0]                    st_code,
    input  byte_wr_t                             sq_bw,
    input  word_wr_t                             sq_ww,
    output logic [NUM_BYTES-1:0][BYTE_W-1:0]     regs,
    output logic [WORD_W-1:0]                    sp
);

    logic [WORD_W-1:0] step_cur;
    logic [WORD_W-1:0] step_nxt;

    always_comb begin
        if (st_code == CODE_SP)
            step_cur = sp;
        else
            step_cur = {regs[hi_idx(st_code, 1'b0)], regs[lo_idx(st_code, 1'b0)]};
        step_nxt = step16(step_cur, st_down);
    end

    for (genvar gi = 0; gi < NUM_BYTES; gi++) begin : g_byte
        localparam logic [IDX_W-1:0] MY = IDX_W'(gi);
        logic [BYTE_W-1:0] q;
        logic [BYTE_W-1:0] d_raw;
        logic [BYTE_W-1:0] d;

        // Later assignments override earlier ones: this is the priority order.
        always_comb begin
            d_raw = q;
            if (bw.en && bw.idx == MY)
                d_raw = bw.data;
            if (ww.en && ww.code != CODE_SP) begin
                if (hi_idx(ww.code, 1'b0) == MY) d_raw = ww.value[15:8];
                if (lo_idx(ww.code, 1'b0) == MY) d_raw = ww.value[7:0];
            end
            if (st_en && st_code != CODE_SP) begin
                if (hi_idx(st_code, 1'b0) == MY) d_raw = step_nxt[15:8];
                if (lo_idx(st_code, 1'b0) == MY) d_raw = step_nxt[7:0];
            end
            if (sq_ww.en && sq_ww.code != CODE_SP) begin
                if (hi_idx(sq_ww.code, 1'b0) == MY) d_raw = sq_ww.value[15:8];
                if (lo_idx(sq_ww.code, 1'b0) == MY) d_raw = sq_ww.value[7:0];
            end
            if (sq_bw.en && sq_bw.idx == MY)
                d_raw = sq_bw.data;
        end

        if (MY == IDX_F) begin : g_flag
            assign d = {d_raw[BYTE_W-1:F_ZERO_BITS], {F_ZERO_BITS{1'b0}}};
        end else begin : g_plain
            assign d = d_raw;
        end

        always_ff @(posedge clk) begin
            if (rst) q <= '0;
            else     q <= d;
        end

        assign regs[gi] = q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            sp <= SP_INIT;
        else if (sq_ww.en && sq_ww.code == CODE_SP)
            sp <= sq_ww.value;
        else if (st_en && st_code == CODE_SP)
            sp <= step_nxt;
        else if (ww.en && ww.code == CODE_SP)
            sp <= ww.value;
    end

endmodule

// File: rtl/pairreg_stack_seq.sv
module pairreg_stack_seq
    import pairreg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  mop_e                 mop,
    input  logic [CODE_W-1:0]    mop_pair,
    input  logic [BYTE_W-1:0]    a_val,
    input  logic [WORD_W-1:0]    hl_val,
    input  logic [WORD_W-1:0]    sp_val,
    input  logic [WORD_W-1:0]    push_word,
    input  logic [BYTE_W-1:0]    mem_rdata,
    output logic                 busy,
    output logic [WORD_W-1:0]    mem_addr,
    output logic                 mem_we,
    output logic                 mem_re,
    output logic [BYTE_W-1:0]    mem_wdata,
    output byte_wr_t             sq_bw,
    output word_wr_t             sq_ww
);

    sq_state_e         state_q, state_d;
    logic [BYTE_W-1:0] lo_q, lo_d;
    logic [CODE_W-1:0] pair_q, pair_d;

    always_comb begin
        state_d   = state_q;
        lo_d      = lo_q;
        pair_d    = pair_q;
        mem_addr  = hl_val;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_wdata = a_val;
        sq_bw     = '0;
        sq_ww     = '0;
        unique case (state_q)
            SQ_IDLE: begin
                unique case (mop)
                    MOP_ST_INC, MOP_ST_DEC: begin
                        mem_we    = 1'b1;
                        mem_addr  = hl_val;
                        mem_wdata = a_val;
                        sq_ww     = '{en: 1'b1, code: CODE_HL,
                                      value: step16(hl_val, mop == MOP_ST_DEC)};
                    end
                    MOP_LD_INC, MOP_LD_DEC: begin
                        mem_re   = 1'b1;
                        mem_addr = hl_val;
                        sq_bw    = '{en: 1'b1, idx: IDX_A, data: mem_rdata};
                        sq_ww    = '{en: 1'b1, code: CODE_HL,
                                     value: step16(hl_val, mop == MOP_LD_DEC)};
                    end
                    MOP_PUSH: begin
                        mem_we    = 1'b1;
                        mem_addr  = sp_val - 16'd1;
                        mem_wdata = push_word[15:8];
                        sq_ww     = '{en: 1'b1, code: CODE_SP, value: sp_val - 16'd1};
                        lo_d      = push_word[7:0];
                        pair_d    = mop_pair;
                        state_d   = SQ_PUSH_LO;
                    end
                    MOP_POP: begin
                        mem_re   = 1'b1;
                        mem_addr = sp_val;
                        sq_bw    = '{en: 1'b1, idx: lo_idx(mop_pair, 1'b1), data: mem_rdata};
                        sq_ww    = '{en: 1'b1, code: CODE_SP, value: sp_val + 16'd1};
                        pair_d   = mop_pair;
                        state_d  = SQ_POP_HI;
                    end
                    default: ;
                endcase
            end
            SQ_PUSH_LO: begin
                mem_we    = 1'b1;
                mem_addr  = sp_val - 16'd1;
                mem_wdata = lo_q;
                sq_ww     = '{en: 1'b1, code: CODE_SP, value: sp_val - 16'd1};
                state_d   = SQ_IDLE;
            end
            SQ_POP_HI: begin
                mem_re   = 1'b1;
                mem_addr = sp_val;
                sq_bw    = '{en: 1'b1, idx: hi_idx(pair_q, 1'b1), data: mem_rdata};
                sq_ww    = '{en: 1'b1, code: CODE_SP, value: sp_val + 16'd1};
                state_d  = SQ_IDLE;
            end
            default: state_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            lo_q    <= '0;
            pair_q  <= '0;
        end else begin
            state_q <= state_d;
            lo_q    <= lo_d;
            pair_q  <= pair_d;
        end
    end

    assign busy = (state_q != SQ_IDLE);

endmodule

// File: rtl/pairreg_file.sv
module pairreg_file
    import pairreg_pkg::*;
#(
    parameter logic [15:0] SP_INIT     = 16'hFFFE,
    parameter int          F_ZERO_BITS = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  rd_byte_sel,
    output logic [7:0]  rd_byte,
    input  logic [1:0]  rd_pair_sel,
    output logic [15:0] rd_pair,
    input  logic        byte_wr_en,
    input  logic [2:0]  byte_wr_sel,
    input  logic [7:0]  byte_wr_data,
    input  logic        ld16_en,
    input  logic [1:0]  ld16_sel,
    input  logic [7:0]  ld16_b0,
    input  logic [7:0]  ld16_b1,
    input  logic        step_en,
    input  logic        step_down,
    input  logic [1:0]  step_sel,
    input  logic [2:0]  mop,
    input  logic [1:0]  mop_pair,
    output logic        busy,
    output logic [15:0] mem_addr,
    output logic        mem_we,
    output logic        mem_re,
    output logic [7:0]  mem_wdata,
    input  logic [7:0]  mem_rdata
);

    logic [NUM_BYTES-1:0][BYTE_W-1:0] regs_w;
    logic [WORD_W-1:0]                sp_w;
    logic [WORD_W-1:0]                hl_w;
    logic [WORD_W-1:0]                push_word_w;
    byte_wr_t                         bw_w, sq_bw_w;
    word_wr_t                         ww_w, sq_ww_w;
    logic                             busy_w;

    // Outer write ports are frozen during the second cycle of a stack transfer.
    assign bw_w = '{en: byte_wr_en & ~busy_w, idx: byte_wr_sel, data: byte_wr_data};
    assign ww_w = '{en: ld16_en & ~busy_w, code: ld16_sel, value: {ld16_b1, ld16_b0}};

    assign hl_w        = {regs_w[hi_idx(CODE_HL, 1'b0)], regs_w[lo_idx(CODE_HL, 1'b0)]};
    assign push_word_w = {regs_w[hi_idx(mop_pair, 1'b1)], regs_w[lo_idx(mop_pair, 1'b1)]};

    pairreg_bank #(
        .SP_INIT     (SP_INIT),
        .F_ZERO_BITS (F_ZERO_BITS)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .bw      (bw_w),
        .ww      (ww_w),
        .st_en   (step_en & ~busy_w),
        .st_down (step_down),
        .st_code (step_sel),
        .sq_bw   (sq_bw_w),
        .sq_ww   (sq_ww_w),
        .regs    (regs_w),
        .sp      (sp_w)
    );

    pairreg_stack_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .mop       (mop_e'(mop)),
        .mop_pair  (mop_pair),
        .a_val     (regs_w[IDX_A]),
        .hl_val    (hl_w),
        .sp_val    (sp_w),
        .push_word (push_word_w),
        .mem_rdata (mem_rdata),
        .busy      (busy_w),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .mem_wdata (mem_wdata),
        .sq_bw     (sq_bw_w),
        .sq_ww     (sq_ww_w)
    );

    assign busy    = busy_w;
    assign rd_byte = regs_w[rd_byte_sel];
    assign rd_pair = (rd_pair_sel == CODE_SP) ? sp_w
                   : {regs_w[hi_idx(rd_pair_sel, 1'b0)], regs_w[lo_idx(rd_pair_sel, 1'b0)]};

endmodule

// File: rtl/pairreg_file_chk.sv
module pairreg_file_chk #(
    parameter logic [15:0] SP_INIT = 16'hFFFE
) (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic [2:0]  mop,
    input logic        mem_we,
    input logic        mem_re,
    input logic [15:0] mem_addr,
    input logic [2:0]  rd_byte_sel,
    input logic [7:0]  rd_byte,
    input logic        step_en,
    input logic        step_down,
    input logic [1:0]  step_sel,
    input logic [15:0] sp,
    input logic [15:0] hl
);

    p_reset_sp_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sp == SP_INIT && !busy));

    p_mem_excl_r13: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));

    p_flag_low_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_byte_sel == 3'd6) |-> (rd_byte[3:0] == 4'd0));

    p_sp_step_r5: assert property (@(posedge clk) disable iff (rst)
        (step_en && !busy && mop == 3'd0 && step_sel == 2'd3 && !step_down)
        |=> (sp == 16'($past(sp) + 16'd1)));

    p_store_hl_r7: assert property (@(posedge clk) disable iff (rst)
        (!busy && (mop == 3'd1 || mop == 3'd2))
        |=> (hl == ($past(mop) == 3'd1 ? 16'($past(hl) + 16'd1) : 16'($past(hl) - 16'd1))));

    p_load_hl_r8: assert property (@(posedge clk) disable iff (rst)
        (!busy && (mop == 3'd3 || mop == 3'd4))
        |=> (hl == ($past(mop) == 3'd3 ? 16'($past(hl) + 16'd1) : 16'($past(hl) - 16'd1))));

    p_push_first_r9: assert property (@(posedge clk) disable iff (rst)
        (!busy && mop == 3'd5) |-> (mem_we && mem_addr == 16'(sp - 16'd1)));

    p_push_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (!busy && mop == 3'd5) |=> busy);

    p_push_sp_r9: assert property (@(posedge clk) disable iff (rst)
        (!busy && mop == 3'd5) |=> ##1 (sp == 16'($past(sp, 2) - 16'd2)));

    p_pop_sp_r10: assert property (@(posedge clk) disable iff (rst)
        (!busy && mop == 3'd6) |=> ##1 (sp == 16'($past(sp, 2) + 16'd2)));

    p_busy_single_r12: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy);

endmodule

bind pairreg_file pairreg_file_chk #(.SP_INIT(SP_INIT)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .busy        (busy),
    .mop         (mop),
    .mem_we      (mem_we),
    .mem_re      (mem_re),
    .mem_addr    (mem_addr),
    .rd_byte_sel (rd_byte_sel),
    .rd_byte     (rd_byte),
    .step_en     (step_en),
    .step_down   (step_down),
    .step_sel    (step_sel),
    .sp          (sp_w),
    .hl          (hl_w)
);

// File: tb/pairreg_file_bench.sv
`timescale 1ns/10ps
module pairreg_file_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  rd_byte_sel;
    logic [7:0]  rd_byte;
    logic [1:0]  rd_pair_sel;
    logic [15:0] rd_pair;
    logic        byte_wr_en;
    logic [2:0]  byte_wr_sel;
    logic [7:0]  byte_wr_data;
    logic        ld16_en;
    logic [1:0]  ld16_sel;
    logic [7:0]  ld16_b0, ld16_b1;
    logic        step_en, step_down;
    logic [1:0]  step_sel;
    logic [2:0]  mop;
    logic [1:0]  mop_pair;
    logic        busy;
    logic [15:0] mem_addr;
    logic        mem_we, mem_re;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;

    logic [7:0]  mem [0:255];
    int          n_checks = 0;
    int          n_errors = 0;

    always #2.5 clk = ~clk;

    always @(posedge clk) if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    assign mem_rdata = mem[mem_addr[7:0]];

    pairreg_file u_pairreg_file (
        .clk(clk), .rst(rst),
        .rd_byte_sel(rd_byte_sel), .rd_byte(rd_byte),
        .rd_pair_sel(rd_pair_sel), .rd_pair(rd_pair),
        .byte_wr_en(byte_wr_en), .byte_wr_sel(byte_wr_sel), .byte_wr_data(byte_wr_data),
        .ld16_en(ld16_en), .ld16_sel(ld16_sel), .ld16_b0(ld16_b0), .ld16_b1(ld16_b1),
        .step_en(step_en), .step_down(step_down), .step_sel(step_sel),
        .mop(mop), .mop_pair(mop_pair), .busy(busy),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        byte_wr_en = 0; byte_wr_sel = 0; byte_wr_data = 0;
        ld16_en = 0; ld16_sel = 0; ld16_b0 = 0; ld16_b1 = 0;
        step_en = 0; step_down = 0; step_sel = 0;
        mop = 0; mop_pair = 0;
    endtask

    task automatic rb(input logic [2:0] idx, output logic [7:0] v);
        rd_byte_sel = idx; #0.1; v = rd_byte;
    endtask

    task automatic rp(input logic [1:0] code, output logic [15:0] v);
        rd_pair_sel = code; #0.1; v = rd_pair;
    endtask

    task automatic wbyte(input logic [2:0] idx, input logic [7:0] v);
        byte_wr_en = 1; byte_wr_sel = idx; byte_wr_data = v;
        cyc(); idle_inputs();
    endtask

    task automatic wword(input logic [1:0] code, input logic [7:0] b0, input logic [7:0] b1);
        ld16_en = 1; ld16_sel = code; ld16_b0 = b0; ld16_b1 = b1;
        cyc(); idle_inputs();
    endtask

    task automatic t_reset();
        logic [7:0] v; logic [15:0] w;
        rst = 1; idle_inputs(); rd_byte_sel = 0; rd_pair_sel = 0;
        for (int i = 0; i < 256; i++) mem[i] = 8'(i);
        repeat (3) cyc();
        rst = 0; #0.1;
        for (int i = 0; i < 8; i++) begin
            rb(3'(i), v); chk("R1 byte reset", {8'h0, v}, 16'h0000);
        end
        rp(2'd3, w); chk("R1 sp reset", w, 16'hFFFE);
        chk("R1 busy reset", {15'h0, busy}, 16'h0);
        chk("R1 mem strobes idle", {14'h0, mem_we, mem_re}, 16'h0);
    endtask

    task automatic t_bytes();
        logic [7:0] v;
        for (int i = 0; i < 8; i++) if (i != 6) wbyte(3'(i), 8'(8'h11 * (i + 1)));
        for (int i = 0; i < 8; i++) if (i != 6) begin
            rb(3'(i), v); chk("R2 byte write/read", {8'h0, v}, {8'h0, 8'(8'h11 * (i + 1))});
        end
        wbyte(3'd6, 8'hFF);
        rb(3'd6, v); chk("R6 flag low nibble via byte write", {8'h0, v}, 16'h00F0);
    endtask

    task automatic t_pairs();
        logic [15:0] w;
        rp(2'd0, w); chk("R3 BC = {B,C}", w, 16'h1122);
        rp(2'd1, w); chk("R3 DE = {D,E}", w, 16'h3344);
        rp(2'd2, w); chk("R3 HL = {H,L}", w, 16'h5566);
    endtask

    task automatic t_ld16();
        logic [7:0] v; logic [15:0] w;
        wword(2'd2, 8'h34, 8'h12);
        rb(3'd4, v); chk("R4 high register gets second operand", {8'h0, v}, 16'h0012);
        rb(3'd5, v); chk("R4 low register gets first operand", {8'h0, v}, 16'h0034);
        wword(2'd3, 8'hF0, 8'hC0);
        rp(2'd3, w); chk("R4 SP load", w, 16'hC0F0);
        wword(2'd3, 8'hFE, 8'hFF);
    endtask

    task automatic t_step();
        logic [15:0] w; logic [7:0] v;
        wbyte(3'd6, 8'hA5);
        wword(2'd1, 8'hFF, 8'hFF);
        step_en = 1; step_sel = 2'd1; step_down = 0; cyc(); idle_inputs();
        rp(2'd1, w); chk("R5 increment wraps to 0000", w, 16'h0000);
        step_en = 1; step_sel = 2'd1; step_down = 1; cyc(); idle_inputs();
        rp(2'd1, w); chk("R5 decrement wraps to FFFF", w, 16'hFFFF);
        step_en = 1; step_sel = 2'd3; step_down = 0; cyc(); idle_inputs();
        rp(2'd3, w); chk("R5 SP increment", w, 16'hFFFF);
        step_en = 1; step_sel = 2'd3; step_down = 1; cyc(); idle_inputs();
        rp(2'd3, w); chk("R5 SP decrement", w, 16'hFFFE);
        rb(3'd6, v); chk("R5 flags unchanged by steps", {8'h0, v}, 16'h00A0);
    endtask

    task automatic t_hl_store();
        logic [15:0] w;
        wword(2'd2, 8'h40, 8'h00);
        wbyte(3'd7, 8'h5A);
        mop = 3'd1; #0.1;
        chk("R7 store strobes", {15'h0, mem_we}, 16'h1);
        chk("R7 store address is HL", mem_addr, 16'h0040);
        chk("R7 store data is A", {8'h0, mem_wdata}, 16'h005A);
        cyc(); idle_inputs();
        rp(2'd2, w); chk("R7 HL post-increment", w, 16'h0041);
        chk("R7 memory written", {8'h0, mem[8'h40]}, 16'h005A);
        mop = 3'd2; cyc(); idle_inputs();
        rp(2'd2, w); chk("R7 HL post-decrement", w, 16'h0040);
        chk("R7 decrement form memory written", {8'h0, mem[8'h41]}, 16'h005A);
    endtask

    task automatic t_hl_load();
        logic [15:0] w; logic [7:0] v;
        mem[8'h80] = 8'h77; mem[8'h81] = 8'h99;
        wword(2'd2, 8'h80, 8'h00);
        mop = 3'd3; #0.1;
        chk("R8 load read strobe", {15'h0, mem_re}, 16'h1);
        chk("R13 no write with read", {15'h0, mem_we}, 16'h0);
        cyc(); idle_inputs();
        rb(3'd7, v); chk("R8 A loaded through HL", {8'h0, v}, 16'h0077);
        rp(2'd2, w); chk("R8 HL post-increment", w, 16'h0081);
        mop = 3'd4; cyc(); idle_inputs();
        rb(3'd7, v); chk("R8 A loaded, decrement form", {8'h0, v}, 16'h0099);
        rp(2'd2, w); chk("R8 HL post-decrement", w, 16'h0080);
    endtask

    task automatic t_push_busy();
        logic [15:0] w; logic [7:0] v;
        wword(2'd0, 8'hEF, 8'hBE);
        wword(2'd1, 8'h22, 8'h11);
        mop = 3'd5; mop_pair = 2'd0; #0.1;
        chk("R9 push first address SP-1", mem_addr, 16'hFFFD);
        chk("R9 push first byte is high", {8'h0, mem_wdata}, 16'h00BE);
        cyc(); idle_inputs();
        // Second cycle: writes on other ports must be ignored (R12)
        byte_wr_en = 1; byte_wr_sel = 3'd0; byte_wr_data = 8'h99;
        step_en = 1; step_sel = 2'd1;
        ld16_en = 1; ld16_sel = 2'd2; ld16_b0 = 8'h01; ld16_b1 = 8'h02;
        mop = 3'd6; #0.1;
        chk("R9 busy in second cycle", {15'h0, busy}, 16'h1);
        chk("R9 push second address SP-2", mem_addr, 16'hFFFC);
        chk("R9 push second byte is low", {8'h0, mem_wdata}, 16'h00EF);
        cyc(); idle_inputs(); #0.1;
        chk("R9 busy clears", {15'h0, busy}, 16'h0);
        rp(2'd3, w); chk("R9 SP lowered by 2", w, 16'hFFFC);
        rb(3'd0, v); chk("R12 byte write ignored while busy", {8'h0, v}, 16'h00BE);
        rp(2'd1, w); chk("R12 step ignored while busy", w, 16'h1122);
        rp(2'd2, w); chk("R12 16-bit load ignored while busy", w, 16'h0080);
        chk("R12 memory op ignored while busy", {15'h0, mem_re}, 16'h0);
        chk("R9 memory high byte", {8'h0, mem[8'hFD]}, 16'h00BE);
        chk("R9 memory low byte", {8'h0, mem[8'hFC]}, 16'h00EF);
    endtask

    task automatic t_pop_af();
        logic [15:0] w; logic [7:0] v;
        mop = 3'd6; mop_pair = 2'd3; #0.1;
        chk("R10 pop reads SP first", mem_addr, 16'hFFFC);
        cyc(); idle_inputs(); #0.1;
        chk("R10 pop second read at SP+1", mem_addr, 16'hFFFD);
        cyc();
        rb(3'd7, v); chk("R10 AF pop high into A", {8'h0, v}, 16'h00BE);
        rb(3'd6, v); chk("R6 AF pop clears low flag bits", {8'h0, v}, 16'h00E0);
        rp(2'd3, w); chk("R10 SP raised by 2", w, 16'hFFFE);
    endtask

    task automatic t_priority();
        logic [15:0] w;
        wword(2'd0, 8'hFF, 8'h10);
        byte_wr_en = 1; byte_wr_sel = 3'd1; byte_wr_data = 8'h55;
        step_en = 1; step_sel = 2'd0; step_down = 0;
        cyc(); idle_inputs();
        rp(2'd0, w); chk("R11 step beats byte write", w, 16'h1100);
        ld16_en = 1; ld16_sel = 2'd2; ld16_b0 = 8'h22; ld16_b1 = 8'h22;
        byte_wr_en = 1; byte_wr_sel = 3'd4; byte_wr_data = 8'h77;
        cyc(); idle_inputs();
        rp(2'd2, w); chk("R11 16-bit load beats byte write", w, 16'h2222);
        wbyte(3'd7, 8'h3C);
        mop = 3'd1; step_en = 1; step_sel = 2'd2; step_down = 1;
        cyc(); idle_inputs();
        rp(2'd2, w); chk("R11 memory op beats step on HL", w, 16'h2223);
    endtask

    initial begin
        #(5.0 * 100000);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    initial begin
        t_reset();
        t_bytes();
        t_pairs();
        t_ld16();
        t_step();
        t_hl_store();
        t_hl_load();
        t_push_busy();
        t_pop_af();
        t_priority();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule